// File: doc/BRIEF.md
# Bipolar Single-Pulse PWM Generator with Control-Cycle Sequencer

This block paces a digital inverter controller. A free-running period timer marks the start of every switching period. At each boundary it asks an external converter for fresh samples. When the converter reports completion, the block starts an external arithmetic unit. When that unit reports completion, the block captures the signed command it produced.

The PWM stage then emits exactly one pulse per period, starting at the period boundary. The pulse goes on the positive-bridge output when the captured command is positive and on the negative-bridge output when it is negative. Its length is the command magnitude scaled down by a power of two and limited to one full period. A command captured during one period is applied from the next boundary on, so a pulse that has already started always runs to its full length.

The timer boundary always restarts the handshake chain, even if the previous chain never finished. With the default 100-clock period, a 2 MHz clock gives a 20 kHz switching rate.

Top module: `bipolar_pwm_seq`

## Requirements
- R1: While reset is held, `pwmPos`, `pwmNeg`, `adcStart` and `calcStart` are low. The timer starts from zero, so the first `adcStart` appears in the first cycle after reset is released. The first period after reset carries no pulse.
- R2: `adcStart` is a single-cycle pulse. It repeats exactly every `PERIOD_CLKS` cycles, and every repeat marks a period boundary.
- R3: `adcDone` sampled high while the block waits for the converter raises `calcStart` for exactly one cycle in the next cycle. `adcDone` at any other time is ignored.
- R4: `calcDone` sampled high while the block waits for the arithmetic unit captures `cmdIn`. `calcDone` at any other time captures nothing.
- R5: A positive captured command holds `pwmPos` high for W consecutive cycles, starting in the `adcStart` cycle of the following period, with `pwmNeg` low. W = |cmd| >> `MAG_SHIFT`.
- R6: A negative captured command (`cmdIn` is two's complement) produces the same kind of pulse on `pwmNeg`, with `pwmPos` low.
- R7: When |cmd| >> `MAG_SHIFT` exceeds `PERIOD_CLKS`, W is clamped to `PERIOD_CLKS`, so the output stays high for the whole period.
- R8: A zero command keeps both outputs low for the whole period.
- R9: `pwmPos` and `pwmNeg` are never high in the same cycle.
- R10: A pulse begins only at a period boundary. A command captured mid-period does not shorten or lengthen the pulse in progress. A period with no new capture repeats the last command.
- R11: A period boundary restarts the chain at the converter step even if the previous chain is unfinished. A `calcDone` that belonged to the abandoned chain is then ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| adcDone | input | 1 | Converter finished sampling |
| calcDone | input | 1 | Arithmetic unit finished; `cmdIn` valid |
| cmdIn | input | CMD_W | Signed command in two's complement |
| adcStart | output | 1 | Start request to the converter, one cycle per period |
| calcStart | output | 1 | Start request to the arithmetic unit |
| pwmPos | output | 1 | Positive-bridge drive pulse |
| pwmNeg | output | 1 | Negative-bridge drive pulse |

## Verification
The bench builds the block with `PERIOD_CLKS` = 20, `CMD_W` = 8 and `MAG_SHIFT` = 1. These values put the clamp within easy reach: the extreme command magnitudes of 128 and 100 scale to 64 and 50 counts, well beyond the 20-count period. The short period also lets a dozen successive periods run one after another. That covers each sign change, full-period pulses back to back, stray and late completion strobes, and an abandoned chain, with every sample position inside a period compared against the expected pulse shape.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADC  = 2'd1,
    SEQ_CALC = 2'd2
  } seqState_e;

  typedef struct packed {
    logic periodTick;
    logic loadCmd;
  } seqStrobes_t;

endpackage

// File: rtl/pwm_seq_ctrl.sv
module pwm_seq_ctrl
  import pwm_seq_pkg::*;
#(
  parameter int PERIOD_CLKS = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        adcDone,
  input  logic        calcDone,
  output logic        adcStart,
  output logic        calcStart,
  output seqStrobes_t strobes
);

  localparam int TW = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;

  logic [TW-1:0] timerCnt;
  seqState_e     state;
  logic          tick;

  assign tick = (timerCnt == '0);

  // Free-running period timer; zero marks the boundary.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (timerCnt == TW'(PERIOD_CLKS - 1)) begin
      timerCnt <= '0;
    end else begin
      timerCnt <= timerCnt + 1'b1;
    end
  end

  // Start/done chain; the boundary always wins and restarts it.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      adcStart  <= 1'b0;
      calcStart <= 1'b0;
    end else begin
      adcStart  <= 1'b0;
      calcStart <= 1'b0;
      if (tick) begin
        state    <= SEQ_ADC;
        adcStart <= 1'b1;
      end else begin
        unique case (state)
          SEQ_ADC: begin
            if (adcDone) begin
              state     <= SEQ_CALC;
              calcStart <= 1'b1;
            end
          end
          SEQ_CALC: begin
            if (calcDone) state <= SEQ_IDLE;
          end
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobes.periodTick = tick;
    strobes.loadCmd    = (state == SEQ_CALC) && calcDone;
  end

endmodule

// File: rtl/pwm_seq_dpath.sv
module pwm_seq_dpath
  import pwm_seq_pkg::*;
#(
  parameter int PERIOD_CLKS = 100,
  parameter int CMD_W       = 12,
  parameter int MAG_SHIFT   = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStrobes_t             strobes,
  input  logic signed [CMD_W-1:0] cmdIn,
  output logic                    pwmPos,
  output logic                    pwmNeg
);

  localparam int CNT_W = $clog2(PERIOD_CLKS + 1);
  localparam int SW    = (CMD_W > CNT_W) ? CMD_W : CNT_W;

  logic             cmdNeg;
  logic [CMD_W-1:0] cmdMag;
  logic [SW-1:0]    scaled;
  logic [CNT_W-1:0] widthNext;

  logic [CNT_W-1:0] pendWidth;
  logic             pendNeg;
  logic [CNT_W-1:0] pulseLeft;
  logic             pulseNeg;

  // Sign/magnitude split, scaling and clamp.
  always_comb begin
    cmdNeg = cmdIn[CMD_W-1];
    cmdMag = cmdNeg ? (~cmdIn + 1'b1) : cmdIn;
    scaled = SW'(cmdMag) >> MAG_SHIFT;
    if (scaled > SW'(PERIOD_CLKS)) begin
      widthNext = CNT_W'(PERIOD_CLKS);
    end else begin
      widthNext = scaled[CNT_W-1:0];
    end
  end

  // Pending command: waits for the next boundary.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendWidth <= '0;
      pendNeg   <= 1'b0;
    end else if (strobes.loadCmd) begin
      pendWidth <= widthNext;
      pendNeg   <= cmdNeg;
    end
  end

  // Active pulse: reloaded only at the boundary, then counts down.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseLeft <= '0;
      pulseNeg  <= 1'b0;
    end else if (strobes.periodTick) begin
      pulseLeft <= pendWidth;
      pulseNeg  <= pendNeg;
    end else if (pulseLeft != '0) begin
      pulseLeft <= pulseLeft - 1'b1;
    end
  end

  assign pwmPos = (pulseLeft != '0) && !pulseNeg;
  assign pwmNeg = (pulseLeft != '0) &&  pulseNeg;

endmodule

// File: rtl/bipolar_pwm_seq.sv
module bipolar_pwm_seq
  import pwm_seq_pkg::*;
#(
  parameter int PERIOD_CLKS = 100,
  parameter int CMD_W       = 12,
  parameter int MAG_SHIFT   = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    adcDone,
  input  logic                    calcDone,
  input  logic signed [CMD_W-1:0] cmdIn,
  output logic                    adcStart,
  output logic                    calcStart,
  output logic                    pwmPos,
  output logic                    pwmNeg
);

  seqStrobes_t strobes;

  pwm_seq_ctrl #(
    .PERIOD_CLKS(PERIOD_CLKS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .adcDone  (adcDone),
    .calcDone (calcDone),
    .adcStart (adcStart),
    .calcStart(calcStart),
    .strobes  (strobes)
  );

  pwm_seq_dpath #(
    .PERIOD_CLKS(PERIOD_CLKS),
    .CMD_W      (CMD_W),
    .MAG_SHIFT  (MAG_SHIFT)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .cmdIn  (cmdIn),
    .pwmPos (pwmPos),
    .pwmNeg (pwmNeg)
  );

endmodule

// File: rtl/bipolar_pwm_seq_checker.sv
module bipolar_pwm_seq_checker #(
  parameter int PERIOD_CLKS = 100
) (
  input logic clk,
  input logic rstN,
  input logic adcStart,
  input logic adcDone,
  input logic calcStart,
  input logic pwmPos,
  input logic pwmNeg
);

  int   gapCnt;
  logic seenStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt    <= 0;
      seenStart <= 1'b0;
    end else if (adcStart) begin
      gapCnt    <= 1;
      seenStart <= 1'b1;
    end else if (gapCnt < PERIOD_CLKS + 2) begin
      gapCnt <= gapCnt + 1;
    end
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(pwmPos && pwmNeg));

  p_first_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (adcStart && !seenStart) |-> (gapCnt == 1));

  p_period_r2: assert property (@(posedge clk) disable iff (!rstN)
    (adcStart && seenStart) |-> (gapCnt == PERIOD_CLKS));

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  p_calc_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    calcStart |-> $past(adcDone));

  p_pos_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmPos) |-> adcStart);

  p_neg_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmNeg) |-> adcStart);

endmodule

bind bipolar_pwm_seq bipolar_pwm_seq_checker #(
  .PERIOD_CLKS(PERIOD_CLKS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .adcStart (adcStart),
  .adcDone  (adcDone),
  .calcStart(calcStart),
  .pwmPos   (pwmPos),
  .pwmNeg   (pwmNeg)
);

// File: tb/bipolar_pwm_seq_test.sv
module bipolar_pwm_seq_test;

  localparam int P  = 20;
  localparam int CW = 8;
  localparam int SH = 1;

  localparam int M_FULL = 0;
  localparam int M_NONE = 1;
  localparam int M_ADC  = 2;
  localparam int M_LATE = 3;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 adcDone = 1'b0;
  logic                 calcDone = 1'b0;
  logic signed [CW-1:0] cmdIn = '0;
  logic                 adcStart, calcStart, pwmPos, pwmNeg;

  int  checks = 0;
  int  fails  = 0;
  int  expW   = 0;
  bit  expNeg = 1'b0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  bipolar_pwm_seq #(
    .PERIOD_CLKS(P),
    .CMD_W      (CW),
    .MAG_SHIFT  (SH)
  ) uut (
    .clk      (clk),
    .rstN     (rstN),
    .adcDone  (adcDone),
    .calcDone (calcDone),
    .cmdIn    (cmdIn),
    .adcStart (adcStart),
    .calcStart(calcStart),
    .pwmPos   (pwmPos),
    .pwmNeg   (pwmNeg)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int widthOf(input logic signed [CW-1:0] c);
    int a = (c < 0) ? -int'(c) : int'(c);
    a = a >> SH;
    return (a > P) ? P : a;
  endfunction

  // Runs one period, entered at the negedge where adcStart is high.
  // Checks the pulse of the previously captured command and drives
  // the handshake for the next one according to mode.
  task automatic doPeriod(input logic signed [CW-1:0] cmd, input int mode,
                          input bit stray, input string req);
    int bad = 0;
    int both = 0;
    int firstBad = -1;
    for (int i = 0; i < P; i++) begin
      bit ep = (i < expW) && !expNeg;
      bit en = (i < expW) &&  expNeg;
      if (pwmPos !== ep || pwmNeg !== en) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
      if (pwmPos && pwmNeg) both++;
      if (i > 0 && adcStart) check(1'b0, "R2", "extra adcStart at offset", i, 0);
      if (mode == M_FULL || mode == M_ADC) begin
        if (i == 1) begin
          check(calcStart == 1'b0, "R3", "calcStart before adcDone", int'(calcStart), 0);
          adcDone = 1'b1;
        end
        if (i == 2) begin
          adcDone = 1'b0;
          check(calcStart == 1'b1, "R3", "calcStart after adcDone", int'(calcStart), 1);
          if (mode == M_FULL) begin
            cmdIn    = cmd;
            calcDone = 1'b1;
          end
        end
        if (i == 3) begin
          calcDone = 1'b0;
          check(calcStart == 1'b0, "R3", "calcStart single cycle", int'(calcStart), 0);
        end
      end
      if (mode == M_LATE) begin
        if (i == 1) begin
          cmdIn    = cmd;
          calcDone = 1'b1;
        end
        if (i == 2) calcDone = 1'b0;
      end
      if (stray) begin
        if (i == 5) adcDone = 1'b1;
        if (i == 6) begin
          adcDone = 1'b0;
          check(calcStart == 1'b0, "R3", "calcStart after stray adcDone", int'(calcStart), 0);
        end
        if (i == 7) begin
          cmdIn    = -8'sd60;
          calcDone = 1'b1;
        end
        if (i == 8) calcDone = 1'b0;
      end
      @(negedge clk);
    end
    check(bad == 0, req, "pulse shape mismatches (first offset)", firstBad, -1);
    check(both == 0, "R9", "cycles with both outputs high", both, 0);
    check(adcStart == 1'b1, "R2", "adcStart at period end", int'(adcStart), 1);
    if (mode == M_FULL) begin
      expW   = widthOf(cmd);
      expNeg = (cmd < 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(!pwmPos && !pwmNeg, "R1", "outputs in reset", int'(pwmPos) + int'(pwmNeg), 0);
    check(!adcStart && !calcStart, "R1", "strobes in reset",
          int'(adcStart) + int'(calcStart), 0);
    rstN = 1'b1;
    check(adcStart == 1'b0, "R1", "adcStart at release", int'(adcStart), 0);
    @(negedge clk);
    check(adcStart == 1'b1, "R1", "first adcStart after release", int'(adcStart), 1);
  endtask

  task automatic t_firstPeriod();   doPeriod(8'sd30, M_FULL, 1'b0, "R1");  endtask
  task automatic t_positive();      doPeriod(-8'sd22, M_FULL, 1'b0, "R5"); endtask
  task automatic t_negative();      doPeriod(8'sd100, M_FULL, 1'b0, "R6"); endtask
  task automatic t_clampPos();      doPeriod(-8'sd128, M_FULL, 1'b0, "R7"); endtask
  task automatic t_clampNeg();      doPeriod(8'sd0, M_FULL, 1'b0, "R7");   endtask
  task automatic t_zeroStray();     doPeriod(8'sd8, M_FULL, 1'b1, "R8");   endtask
  task automatic t_strayIgnored();  doPeriod(8'sd0, M_NONE, 1'b0, "R4");   endtask
  task automatic t_repeatAbandon(); doPeriod(8'sd0, M_ADC, 1'b0, "R10");   endtask
  task automatic t_lateCalc();      doPeriod(8'sd40, M_LATE, 1'b0, "R10"); endtask
  task automatic t_restartLoad();   doPeriod(8'sd10, M_FULL, 1'b0, "R11"); endtask
  task automatic t_afterRestart();  doPeriod(-8'sd6, M_FULL, 1'b0, "R11"); endtask
  task automatic t_lastPulse();     doPeriod(8'sd0, M_NONE, 1'b0, "R6");   endtask

  initial begin
    t_reset();
    t_firstPeriod();    // R1: no pulse in first period
    t_positive();       // R5: +30 -> 15 on pwmPos
    t_negative();       // R6: -22 -> 11 on pwmNeg; R10 no truncation
    t_clampPos();       // R7: 100 -> 50 clamped to 20
    t_clampNeg();       // R7: -128 -> 64 clamped to 20 on pwmNeg
    t_zeroStray();      // R8: zero; stray strobes after capture
    t_strayIgnored();   // R4: stray calcDone ignored, 8 -> 4 positive
    t_repeatAbandon();  // R10: no capture repeats last command
    t_lateCalc();       // R10/R11: chain abandoned, last repeats
    t_restartLoad();    // R11: late calcDone of 40 ignored
    t_afterRestart();   // R11: restarted chain captures 10 -> 5
    t_lastPulse();      // R6: -6 -> 3 on pwmNeg
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule